// File: doc/BRIEF.md
# Linked-List Summing Walker

This block adds up the signed 8-bit numbers held in a singly linked list that lives in an external, single-ported memory. Every node occupies two consecutive words: the word at the node's own address holds the address of the next node, and the word one above it holds the node's two's-complement value. The first node always sits at address 0. A link of 0 ends the list, and the list always has at least one node.

A pulse on `start` sends the walker back to address 0 and zeroes its running total. The memory answers a read in the same cycle the address is presented, and it serves one read per cycle. Each node therefore costs two cycles. In the first cycle the walker reads the value at link address plus one and adds it in. In the second it reads the link and moves to it. When a zero link has been taken, one further cycle copies the total to `result` and raises `done`. Both hold until the next `start`.

A small state machine drives the address select and the load enables of a pointer register, a total register and a result register. These three registers live in a separate datapath.

Top module: `llist_summer`

## Requirements
- R1: While `rst` is high at a clock edge, the walker goes idle with `done` low, `result` at 0 and `mem_addr` at 0.
- R2: `start` high at an edge clears the node pointer and the total, whatever the current state. In the cycle after that edge, `mem_addr` is 1, which is the value word of the head node at address 0.
- R3: Each node takes exactly two cycles. The first presents node address + 1 on `mem_addr` and adds `mem_rdata` into the total. The second presents the node address and loads `mem_rdata` as the next node address. The total does not change during the link cycle.
- R4: After the link cycle that reads 0, one finishing cycle follows. `done` is then high, and `result` equals the sum of all node values. For an N-node list, `done` first reads high after edge 2N+1, counting the edge that sampled `start` as edge 0.
- R5: The sum is taken modulo 256 in two's complement. For example, 100+100+100 gives 44 and -5+3 gives 254 (0xFE). Overflow raises no flag.
- R6: Once `done` is high, `done` and `result` hold their values until the next `start`. Changes to memory contents while idle have no effect on them.
- R7: A `start` that arrives in the middle of a walk abandons it. The walk then begins again from address 0 with a zero total.
- R8: `done` is low in the cycle after `start` is sampled. `result` keeps its previous value until the new walk finishes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin (or restart) a walk from address 0 |
| mem_addr | output | 8 | Read address to the external memory |
| mem_rdata | input | 8 | Read data from the memory, valid in the same cycle |
| result | output | 8 | Sum of node values, held after a walk |
| done | output | 1 | High once a walk has finished, until the next start |

## Verification
The walker is tried on several lists:
- A one-node list, where the head's link is already 0. It separates the end test from the first add.
- A four-node chain with scattered, non-ascending addresses and mixed-sign values. It shows that links, not address order, drive the walk.
- Lists whose sums pass +127 or go below zero. They expose any widening or saturation of the total.

Every address presented during a walk is compared with the bench's own pointer chase, and the cycle at which `done` rises is compared with 2N+1. Further scenarios rewrite memory after a finish, restart with a pulse mid-walk and pulse `start` after a finish. Together they separate holding behaviour from a fresh walk.

// File: rtl/llsum_pkg.sv
package llsum_pkg;

    // Phases of the list walk
    typedef enum logic [1:0] {
        WALK_IDLE   = 2'd0,
        WALK_VALUE  = 2'd1,
        WALK_LINK   = 2'd2,
        WALK_FINISH = 2'd3
    } walk_state_e;

    // Datapath control bundle produced by the sequencer
    typedef struct packed {
        logic clear;     // zero pointer and total
        logic sel_value; // address = pointer + 1 instead of pointer
        logic total_ld;  // accumulate read data
        logic ptr_ld;    // take read data as next node address
        logic res_ld;    // copy total to result
    } walk_ctl_t;

endpackage

// File: rtl/llsum_seq.sv
module llsum_seq
    import llsum_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        start,
    input  logic        link_zero,
    output walk_ctl_t   ctl,
    output walk_state_e state,
    output logic        done
);

    typedef struct packed {
        walk_state_e state;
        logic        done;
    } seq_regs_t;

    localparam seq_regs_t SEQ_RESET = '{state: WALK_IDLE, done: 1'b0};

    seq_regs_t seq_d, seq_q;

    always_comb begin
        seq_d = seq_q;
        ctl   = '0;
        if (start) begin
            ctl.clear   = 1'b1;
            seq_d.state = WALK_VALUE;
            seq_d.done  = 1'b0;
        end else begin
            unique case (seq_q.state)
                WALK_IDLE: begin
                    seq_d.state = WALK_IDLE;
                end
                WALK_VALUE: begin
                    ctl.sel_value = 1'b1;
                    ctl.total_ld  = 1'b1;
                    seq_d.state   = WALK_LINK;
                end
                WALK_LINK: begin
                    ctl.ptr_ld  = 1'b1;
                    seq_d.state = link_zero ? WALK_FINISH : WALK_VALUE;
                end
                WALK_FINISH: begin
                    ctl.res_ld  = 1'b1;
                    seq_d.done  = 1'b1;
                    seq_d.state = WALK_IDLE;
                end
                default: seq_d.state = WALK_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) seq_q <= SEQ_RESET;
        else     seq_q <= seq_d;
    end

    assign state = seq_q.state;
    assign done  = seq_q.done;

    // Value cycle is always followed by the link cycle of the same node
    assert_value_then_link_R3: assert property (@(posedge clk) disable iff (rst)
        (seq_q.state == WALK_VALUE && !start) |=> (seq_q.state == WALK_LINK));

    // Only one phase state at a time, and done never high mid-walk
    assert_done_idle_only_R4: assert property (@(posedge clk) disable iff (rst)
        seq_q.done |-> (seq_q.state == WALK_IDLE));

endmodule

// File: rtl/llsum_path.sv
module llsum_path
    import llsum_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  walk_ctl_t    ctl,
    input  logic [W-1:0] rdata,
    output logic [W-1:0] addr,
    output logic         link_zero,
    output logic [W-1:0] total,
    output logic [W-1:0] result
);

    localparam logic [W-1:0] ONE = W'(1);

    typedef struct packed {
        logic [W-1:0] ptr;
        logic [W-1:0] total;
        logic [W-1:0] result;
    } path_regs_t;

    localparam path_regs_t PATH_RESET = '{ptr: '0, total: '0, result: '0};

    path_regs_t path_d, path_q;

    always_comb begin
        path_d = path_q;
        if (ctl.clear) begin
            path_d.ptr   = '0;
            path_d.total = '0;
        end else begin
            if (ctl.total_ld) path_d.total = path_q.total + rdata;
            if (ctl.ptr_ld)   path_d.ptr   = rdata;
        end
        if (ctl.res_ld) path_d.result = path_q.total;
    end

    always_ff @(posedge clk) begin
        if (rst) path_q <= PATH_RESET;
        else     path_q <= path_d;
    end

    assign addr      = ctl.sel_value ? (path_q.ptr + ONE) : path_q.ptr;
    assign link_zero = (rdata == '0);
    assign total     = path_q.total;
    assign result    = path_q.result;

    // Result register moves only when the sequencer asks for it
    assert_result_load_only_R6: assert property (@(posedge clk) disable iff (rst)
        !ctl.res_ld |=> $stable(path_q.result));

endmodule

// File: rtl/llist_summer.sv
module llist_summer
    import llsum_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start,
    output logic [W-1:0] mem_addr,
    input  logic [W-1:0] mem_rdata,
    output logic [W-1:0] result,
    output logic         done
);

    walk_ctl_t    ctl;
    walk_state_e  state;
    logic         link_zero;
    logic [W-1:0] total;

    llsum_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .link_zero (link_zero),
        .ctl       (ctl),
        .state     (state),
        .done      (done)
    );

    llsum_path #(.W(W)) u_path (
        .clk       (clk),
        .rst       (rst),
        .ctl       (ctl),
        .rdata     (mem_rdata),
        .addr      (mem_addr),
        .link_zero (link_zero),
        .total     (total),
        .result    (result)
    );

    // First access after start is the head's value word
    assert_start_head_R2: assert property (@(posedge clk) disable iff (rst)
        start |=> (mem_addr == W'(1)));

    // Total untouched during a link cycle
    assert_total_hold_link_R3: assert property (@(posedge clk) disable iff (rst)
        (state == WALK_LINK && !start) |=> (total == $past(total)));

    // Value cycle adds the read word with modulo wrap
    assert_total_wrap_R5: assert property (@(posedge clk) disable iff (rst)
        (state == WALK_VALUE && !start) |=> (total == W'($past(total) + $past(mem_rdata))));

    // done rises only two cycles after a zero link was read
    assert_done_after_null_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(done) |-> ($past(state, 2) == WALK_LINK && $past(mem_rdata, 2) == '0));

    // start always drops done on the following cycle
    assert_start_drops_done_R8: assert property (@(posedge clk) disable iff (rst)
        start |=> !done);

    // result only changes when leaving the finishing cycle
    assert_result_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (state != WALK_FINISH) |=> $stable(result));

    // a restart mid-walk returns to the value phase
    assert_restart_R7: assert property (@(posedge clk) disable iff (rst)
        (start && state != WALK_IDLE) |=> (state == WALK_VALUE));

endmodule

// File: tb/tb_llist_summer.sv
`timescale 1ns/1ps
module tb_llist_summer;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start = 1'b0;
    logic [7:0] mem_addr;
    logic [7:0] mem_rdata;
    logic [7:0] result;
    logic       done;

    logic [7:0] mem [256];

    int total = 0;
    int bad   = 0;

    always #4 clk = ~clk;

    assign mem_rdata = mem[mem_addr];

    llist_summer dut (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .mem_addr  (mem_addr),
        .mem_rdata (mem_rdata),
        .result    (result),
        .done      (done)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic clear_mem();
        for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    endtask

    task automatic put_node(input logic [7:0] at, input logic [7:0] link,
                            input logic [7:0] val);
        mem[at]        = link;
        mem[at + 8'd1] = val;
    endtask

    task automatic pulse_start();
        @(negedge clk);
        start = 1'b1;
        @(posedge clk);
        #1 start = 1'b0;
    endtask

    // Independent pointer chase over the bench memory
    task automatic walk_model(output int n, output logic [7:0] sum);
        logic [7:0] p;
        p   = 8'd0;
        n   = 0;
        sum = 8'd0;
        do begin
            sum = sum + mem[p + 8'd1];
            n++;
            p = mem[p];
        end while (p != 8'd0 && n < 128);
    endtask

    // Full walk with per-cycle address check and finish timing (R2, R3, R4)
    task automatic run_walk(input string tag);
        int n;
        logic [7:0] exp_sum;
        logic [7:0] ep;
        walk_model(n, exp_sum);
        ep = 8'd0;
        pulse_start();
        for (int k = 0; k <= 2 * n + 1; k++) begin
            if (k > 0) @(posedge clk);
            @(negedge clk);
            if (k == 0)
                chk(mem_addr == 8'd1, "R2", {tag, " head value address"}, mem_addr, 1);
            if (k < 2 * n) begin
                if (k % 2 == 0) begin
                    chk(mem_addr == ep + 8'd1, "R3", {tag, " value address"},
                        mem_addr, ep + 8'd1);
                end else begin
                    chk(mem_addr == ep, "R3", {tag, " link address"}, mem_addr, ep);
                    ep = mem[ep];
                end
            end
            if (k == 2 * n)
                chk(done == 1'b0, "R4", {tag, " done early"}, done, 0);
            if (k == 2 * n + 1) begin
                chk(done == 1'b1, "R4", {tag, " done at 2N+1"}, done, 1);
                chk(result == exp_sum, "R4", {tag, " result"}, result, exp_sum);
            end
        end
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(done == 1'b0, "R1", "reset done", done, 0);
        chk(result == 8'd0, "R1", "reset result", result, 0);
        chk(mem_addr == 8'd0, "R1", "reset address", mem_addr, 0);
        rst = 1'b0;
    endtask

    task automatic t_single();
        clear_mem();
        put_node(8'd0, 8'd0, 8'd42);
        run_walk("single");
    endtask

    task automatic t_chain();
        clear_mem();
        put_node(8'd0,   8'd20,  8'd5);
        put_node(8'd20,  8'd7,   8'hFD);
        put_node(8'd7,   8'd100, 8'd17);
        put_node(8'd100, 8'd0,   8'd9);
        run_walk("chain");
        chk(result == 8'd28, "R4", "chain total 28", result, 28);
    endtask

    task automatic t_wrap();
        clear_mem();
        put_node(8'd0,  8'd50, 8'd100);
        put_node(8'd50, 8'd90, 8'd100);
        put_node(8'd90, 8'd0,  8'd100);
        run_walk("wrap_pos");
        chk(result == 8'd44, "R5", "300 mod 256", result, 44);
        clear_mem();
        put_node(8'd0,  8'd30, 8'hFB);
        put_node(8'd30, 8'd0,  8'd3);
        run_walk("wrap_neg");
        chk(result == 8'hFE, "R5", "-5+3", result, 254);
    endtask

    task automatic t_hold();
        logic [7:0] kept;
        kept = result;
        mem[1] = mem[1] + 8'd77;
        mem[0] = 8'd0;
        repeat (15) @(posedge clk);
        @(negedge clk);
        chk(done == 1'b1, "R6", "done held", done, 1);
        chk(result == kept, "R6", "result held after memory change", result, kept);
        pulse_start();
        @(negedge clk);
        chk(done == 1'b0, "R8", "done low after start", done, 0);
        chk(result == kept, "R8", "result kept during new walk", result, kept);
    endtask

    task automatic t_abort();
        clear_mem();
        put_node(8'd0,  8'd40, 8'd1);
        put_node(8'd40, 8'd60, 8'd2);
        put_node(8'd60, 8'd80, 8'd3);
        put_node(8'd80, 8'd0,  8'd4);
        pulse_start();
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(done == 1'b0, "R7", "mid-walk done", done, 0);
        mem[41] = 8'd50;
        run_walk("abort");
        chk(result == 8'd58, "R7", "restart total", result, 58);
    endtask

    initial begin
        clear_mem();
        t_reset();
        t_single();
        t_chain();
        t_wrap();
        t_hold();
        t_abort();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(8 * 200000);
        bad++;
        total++;
        $display("FAIL watchdog run did not finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule